// File: doc/BRIEF.md
# Receive Descriptor Ring Walker

This block is the descriptor engine on the receive side of a frame DMA controller. Software builds a circular list of receive descriptors in memory. Each descriptor starts on a 16-byte boundary, and its first word carries an ownership flag, a list-end flag, an abort flag and a frame-status field. When software issues a start command, the walker loads the ring base address. From there it works through the ring one descriptor at a time. For each descriptor it fetches the status word. If software has handed the buffer over, the walker passes the descriptor to the frame-transfer datapath and waits for that datapath to report that the frame is complete or aborted. It then writes the status word back with ownership returned to software.

The walker moves to the next descriptor at the next 16-byte slot, or back to the ring base when the list-end flag is set. It halts as soon as a fetched descriptor is still owned by software. After that it does nothing until software issues a new start command. The payload movement, the FIFO and the MAC are outside this block; they appear only as a go / done / abort handshake. Descriptor memory is reached through a single-word request/ready port, and only one access is in flight at any time.

Top module: `rx_ring_walker`

## Requirements
- R1: After reset, `running_o`, `mem_req_o` and `xfer_go_o` are all 0.
- R2: A one-cycle `start_i` while stopped latches `ring_base_i`. `running_o` rises on the next cycle, and on that same cycle the walker issues a read (`mem_we_o`=0) at the base address.
- R3: Only one memory access is outstanding at a time. While `mem_req_o` is 1 and `mem_ready_i` is 0, the request, address and direction hold steady. The access completes on the cycle in which both are 1, and read data is taken from `mem_rdata_i` on that cycle.
- R4: When a fetched word has bit 31 (active) set to 1, `xfer_go_o` rises on the next cycle. It stays high until `xfer_done_i` or `xfer_abort_i` is seen, and `xfer_desc_addr_o` gives the descriptor address for that whole time.
- R5: On normal completion, the walker writes back to the address it just read. The written word has bit 31 = 0, bit 29 = 0 and bits 7:0 = `xfer_stat_i` as sampled with `xfer_done_i`. Bit 30 and bits 28:8 keep the values that were read.
- R6: On abort (`xfer_abort_i`, which takes priority over done), the write-back has bit 31 = 0, bit 29 = 1 and bits 7:0 = `xfer_stat_i`. All other bits are preserved, as in R5.
- R7: After a write-back to a descriptor whose bit 30 (last) is 0, the next read is at that address plus 16.
- R8: After a write-back to a descriptor whose bit 30 is 1, the next read is at the latched ring base.
- R9: A fetched word with bit 31 = 0 drops `running_o` on the next cycle. That descriptor gets no write-back and the walker makes no further memory access.
- R10: After stopping, a new `start_i` restarts the walk from a newly latched base. The walker re-reads the descriptor, so one that software has re-armed is processed.
- R11: A `start_i` while `running_o` is 1 is ignored. Neither the base nor the access sequence changes, even if `ring_base_i` has a different value at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Receive-initiation pulse from software |
| ring_base_i | input | AW | Ring base address, latched on an accepted start |
| mem_req_o | output | 1 | Descriptor memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Byte address of the descriptor status word |
| mem_wdata_o | output | 32 | Write-back word |
| mem_rdata_i | input | 32 | Read data, valid while mem_ready_i is 1 |
| mem_ready_i | input | 1 | Access completes on this cycle |
| xfer_go_o | output | 1 | Buffer handed to the frame datapath |
| xfer_desc_addr_o | output | AW | Descriptor being filled |
| xfer_done_i | input | 1 | Frame finished normally |
| xfer_abort_i | input | 1 | Frame suspended or aborted |
| xfer_stat_i | input | 8 | Frame status bits to record |
| running_o | output | 1 | Walker active |

## Verification
The assertions check the per-cycle rules on every cycle:
- the request is held stable until ready;
- a write-back lands on the address just read and never leaves the active flag set;
- an active fetch raises go on the next cycle;
- an inactive fetch stops the walker;
- the pointer either steps by the stride or returns to the base.

Only the bench scenarios can show the multi-descriptor behaviour:
- the whole access order around a wrapped ring;
- the field-by-field content of completed and aborted write-backs;
- the fact that a second start while running leaves the sequence untouched;
- a restart on a re-armed descriptor after a halt.

// File: rtl/rxw_pkg.sv
// Shared constants and types of the receive descriptor ring walker.
// Assumes a 32-bit descriptor status word. The frame-status field sits in
// the low bits, below the abort flag.
package rxw_pkg;
    localparam int WORD_W   = 32;
    localparam int ACT_BIT  = 31;  // 1: buffer owned by the walker
    localparam int LAST_BIT = 30;  // 1: final descriptor of the ring
    localparam int ABRT_BIT = 29;  // written 1 when the frame was aborted
    localparam int STAT_W   = 8;   // frame-status field width at [STAT_W-1:0]

    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_FETCH = 2'd1,
        ST_XFER  = 2'd2,
        ST_WBACK = 2'd3
    } rxw_state_e;
endpackage

// File: rtl/rxw_addr_gen.sv
// Descriptor pointer of the ring walker.
// Latches the ring base on load. On advance it either steps by STRIDE
// bytes or returns to the latched base when the wrap flag is set.
// Assumes load and advance are never raised on the same cycle.
module rxw_addr_gen #(
    parameter int AW     = 16,
    parameter int STRIDE = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] base_i,
    input  logic          adv_i,
    input  logic          wrap_i,
    output logic [AW-1:0] addr_o
);
    localparam logic [AW-1:0] STEP = AW'(STRIDE);

    logic [AW-1:0] base_q;
    logic [AW-1:0] cur_q;

    // Ring base register, written only when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)      base_q <= '0;
        else if (load_i) base_q <= base_i;
    end

    // Current descriptor pointer: load, step, or wrap to base.
    always_ff @(posedge clk) begin
        if (!rst_n)      cur_q <= '0;
        else if (load_i) cur_q <= base_i;
        else if (adv_i)  cur_q <= wrap_i ? base_q : cur_q + STEP;
    end

    assign addr_o = cur_q;

    AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && wrap_i && !load_i) |=> (addr_o == base_q)) else $error("wrap missed base"); // R8
    AST_STEP_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !wrap_i && !load_i) |=> (addr_o == $past(addr_o) + STEP)) else $error("bad step"); // R7
endmodule

// File: rtl/rxw_wb_merge.sv
// Builds the write-back status word from the fetched one.
// Clears the active flag, records the abort flag and inserts the frame
// status. Every other bit, including the list-end flag, is preserved.
// Purely combinational.
module rxw_wb_merge
    import rxw_pkg::*;
(
    input  logic [WORD_W-1:0] desc_i,
    input  logic [STAT_W-1:0] stat_i,
    input  logic              abort_i,
    output logic [WORD_W-1:0] wdata_o
);
    // Overlay the fields the walker owns onto the fetched word.
    always_comb begin
        wdata_o                = desc_i;
        wdata_o[ACT_BIT]       = 1'b0;
        wdata_o[ABRT_BIT]      = abort_i;
        wdata_o[STAT_W-1:0]    = stat_i;
    end
endmodule

// File: rtl/rxw_ctrl.sv
// Control sequencer of the ring walker.
// It stops, fetches a status word, hands the buffer to the datapath,
// writes the word back and fetches again. It halts on a software-owned
// descriptor. It also holds the fetched word and the frame outcome used for
// the write-back. Assumes that memory completes an access by raising ready
// for one cycle.
module rxw_ctrl
    import rxw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mem_ready_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    input  logic              done_i,
    input  logic              abort_i,
    input  logic [STAT_W-1:0] stat_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic              go_o,
    output logic              running_o,
    output logic              load_o,
    output logic              adv_o,
    output logic              wrap_o,
    output logic [WORD_W-1:0] desc_o,
    output logic [STAT_W-1:0] stat_o,
    output logic              abrt_o
);
    rxw_state_e state_q, state_d;
    logic       rd_hs, wb_hs, frame_end;
    logic [WORD_W-1:0] desc_q;
    logic [STAT_W-1:0] stat_q;
    logic              abrt_q;

    assign rd_hs     = (state_q == ST_FETCH) && mem_ready_i;
    assign wb_hs     = (state_q == ST_WBACK) && mem_ready_i;
    assign frame_end = (state_q == ST_XFER) && (done_i || abort_i);

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP:  if (start_i)  state_d = ST_FETCH;
            ST_FETCH: if (rd_hs)    state_d = mem_rdata_i[ACT_BIT] ? ST_XFER : ST_STOP;
            ST_XFER:  if (frame_end) state_d = ST_WBACK;
            ST_WBACK: if (wb_hs)    state_d = ST_FETCH;
            default:                state_d = ST_STOP;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    // Capture the fetched status word on a completed read.
    always_ff @(posedge clk) begin
        if (!rst_n)     desc_q <= '0;
        else if (rd_hs) desc_q <= mem_rdata_i;
    end

    // Capture the frame outcome; abort wins over done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            abrt_q <= 1'b0;
        end else if (frame_end) begin
            stat_q <= stat_i;
            abrt_q <= abort_i;
        end
    end

    assign mem_req_o = (state_q == ST_FETCH) || (state_q == ST_WBACK);
    assign mem_we_o  = (state_q == ST_WBACK);
    assign go_o      = (state_q == ST_XFER);
    assign running_o = (state_q != ST_STOP);
    assign load_o    = (state_q == ST_STOP) && start_i;
    assign adv_o     = wb_hs;
    assign wrap_o    = desc_q[LAST_BIT];
    assign desc_o    = desc_q;
    assign stat_o    = stat_q;
    assign abrt_o    = abrt_q;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_we_o))) else $error("request dropped"); // R3
    AST_GO_ON_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hs && mem_rdata_i[ACT_BIT]) |=> go_o) else $error("no go after active fetch"); // R4
    AST_HALT_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hs && !mem_rdata_i[ACT_BIT]) |=> (!running_o && !mem_req_o)) else $error("no halt"); // R9
    AST_GO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (go_o && !done_i && !abort_i) |=> go_o) else $error("go dropped early"); // R4
endmodule

// File: rtl/rx_ring_walker.sv
// Receive descriptor ring walker, top level.
// Connects the sequencer, the descriptor pointer and the write-back merge
// to a single-word descriptor memory port and a frame-transfer handshake.
// Assumes the descriptor status word is the first word of each descriptor.
module rx_ring_walker
    import rxw_pkg::*;
#(
    parameter int AW     = 16,
    parameter int STRIDE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [AW-1:0]     ring_base_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic [WORD_W-1:0] mem_rdata_i,
    input  logic              mem_ready_i,
    output logic              xfer_go_o,
    output logic [AW-1:0]     xfer_desc_addr_o,
    input  logic              xfer_done_i,
    input  logic              xfer_abort_i,
    input  logic [STAT_W-1:0] xfer_stat_i,
    output logic              running_o
);
    logic              load, adv, wrap, abrt;
    logic [WORD_W-1:0] desc;
    logic [STAT_W-1:0] stat;
    logic [AW-1:0]     cur_addr;

    rxw_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .mem_ready_i (mem_ready_i),
        .mem_rdata_i (mem_rdata_i),
        .done_i      (xfer_done_i),
        .abort_i     (xfer_abort_i),
        .stat_i      (xfer_stat_i),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .go_o        (xfer_go_o),
        .running_o   (running_o),
        .load_o      (load),
        .adv_o       (adv),
        .wrap_o      (wrap),
        .desc_o      (desc),
        .stat_o      (stat),
        .abrt_o      (abrt)
    );

    rxw_addr_gen #(.AW(AW), .STRIDE(STRIDE)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .base_i (ring_base_i),
        .adv_i  (adv),
        .wrap_i (wrap),
        .addr_o (cur_addr)
    );

    rxw_wb_merge u_merge (
        .desc_i  (desc),
        .stat_i  (stat),
        .abort_i (abrt),
        .wdata_o (mem_wdata_o)
    );

    assign mem_addr_o       = cur_addr;
    assign xfer_desc_addr_o = cur_addr;

    // Address of the last completed read, used only by the checks below.
    logic [AW-1:0] rd_addr_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                                rd_addr_q <= '0;
        else if (mem_req_o && !mem_we_o && mem_ready_i) rd_addr_q <= mem_addr_o;
    end

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=> $stable(mem_addr_o)) else $error("address moved"); // R3
    AST_WB_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |-> (mem_addr_o == rd_addr_q)) else $error("write-back address"); // R5
    AST_WB_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |-> !mem_wdata_o[ACT_BIT]) else $error("active left set"); // R5
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && start_i && !mem_req_o) |=> $stable(xfer_desc_addr_o)) else $error("start while running"); // R11
endmodule

// File: tb/rx_ring_walker_tb.sv
`timescale 1ns/1ps
module rx_ring_walker_tb;
    localparam int AW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [AW-1:0] ring_base_i = '0;
    logic        mem_req_o, mem_we_o;
    logic [AW-1:0] mem_addr_o;
    logic [31:0] mem_wdata_o;
    logic [31:0] mem_rdata_i = '0;
    logic        mem_ready_i = 1'b0;
    logic        xfer_go_o;
    logic [AW-1:0] xfer_desc_addr_o;
    logic        xfer_done_i = 1'b0;
    logic        xfer_abort_i = 1'b0;
    logic [7:0]  xfer_stat_i = '0;
    logic        running_o;

    always #2.5 clk = ~clk;

    rx_ring_walker #(.AW(AW), .STRIDE(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ring_base_i(ring_base_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ready_i(mem_ready_i),
        .xfer_go_o(xfer_go_o), .xfer_desc_addr_o(xfer_desc_addr_o),
        .xfer_done_i(xfer_done_i), .xfer_abort_i(xfer_abort_i), .xfer_stat_i(xfer_stat_i),
        .running_o(running_o)
    );

    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [31:0] data;
        logic [7:0]  req;   // requirement number for the message
    } acc_t;
    typedef struct packed {
        logic       ab;
        logic [7:0] st;
    } frm_t;

    acc_t exp_q[$];
    frm_t frm_q[$];
    logic [31:0] mem [256];
    int nchk = 0, nerr = 0;
    int lat = 0;
    int wcnt = 0;
    int fcnt = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write-back word expected from R5/R6.
    function automatic logic [31:0] wb_word(input logic [31:0] w, input logic ab, input logic [7:0] st);
        return {1'b0, w[30], ab, w[28:8], st};
    endfunction

    task automatic exp_rd(input logic [15:0] a, input logic [7:0] r);
        exp_q.push_back('{we:1'b0, addr:a, data:32'h0, req:r});
    endtask
    task automatic exp_wr(input logic [15:0] a, input logic [31:0] d, input logic [7:0] r);
        exp_q.push_back('{we:1'b1, addr:a, data:d, req:r});
    endtask

    // Memory model and scoreboard monitor: one handshake per ready cycle.
    always @(negedge clk) begin
        if (!mem_req_o) begin
            mem_ready_i = 1'b0;
            wcnt = 0;
        end else if (mem_ready_i) begin
            mem_ready_i = 1'b0;
            wcnt = 0;
        end else if (wcnt >= lat) begin
            mem_ready_i = 1'b1;
        end else begin
            wcnt++;
        end
        mem_rdata_i = mem[mem_addr_o[9:2]];
        if (mem_req_o && mem_ready_i && rst_n) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected access", {16'h0, mem_addr_o}, 32'h0);
            end else begin
                acc_t e;
                e = exp_q.pop_front();
                chk(mem_we_o == e.we, $sformatf("R%0d direction", e.req), {31'h0, mem_we_o}, {31'h0, e.we});
                chk(mem_addr_o == e.addr, $sformatf("R%0d address", e.req), {16'h0, mem_addr_o}, {16'h0, e.addr});
                if (e.we)
                    chk(mem_wdata_o == e.data, $sformatf("R%0d write-back", e.req), mem_wdata_o, e.data);
            end
            if (mem_we_o) mem[mem_addr_o[9:2]] = mem_wdata_o;
        end
    end

    // Frame datapath model: finishes each handed-over buffer from the plan queue.
    always @(negedge clk) begin
        if (xfer_done_i || xfer_abort_i) begin
            xfer_done_i = 1'b0;
            xfer_abort_i = 1'b0;
            fcnt = 0;
        end else if (xfer_go_o) begin
            if (fcnt < 3) fcnt++;
            else if (frm_q.size() == 0) chk(1'b0, "R4 unplanned go", 32'h1, 32'h0);
            else begin
                frm_t f;
                f = frm_q.pop_front();
                xfer_stat_i = f.st;
                if (f.ab) xfer_abort_i = 1'b1;
                else      xfer_done_i = 1'b1;
            end
        end
    end

    task automatic pulse_start(input logic [15:0] base);
        @(negedge clk);
        ring_base_i = base;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_stop(input string req);
        int n = 0;
        while (running_o && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk(!running_o, req, {31'h0, running_o}, 32'h0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] w0, w1, w2;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(!running_o, "R1 running", {31'h0, running_o}, 0);
        chk(!mem_req_o, "R1 req", {31'h0, mem_req_o}, 0);
        chk(!xfer_go_o, "R1 go", {31'h0, xfer_go_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Scenario 1: three-descriptor ring, wrap, halt on own write-back (R2 R5 R6 R7 R8 R9)
        w0 = 32'hA000_5A00; w1 = 32'h8123_4500; w2 = 32'hC0AB_CD77;
        mem[8'h40] = w0; mem[8'h44] = w1; mem[8'h48] = w2;
        frm_q.push_back('{ab:1'b0, st:8'h11});
        frm_q.push_back('{ab:1'b1, st:8'h22});
        frm_q.push_back('{ab:1'b0, st:8'h33});
        exp_rd(16'h0100, 2); exp_wr(16'h0100, wb_word(w0, 1'b0, 8'h11), 5);
        exp_rd(16'h0110, 7); exp_wr(16'h0110, wb_word(w1, 1'b1, 8'h22), 6);
        exp_rd(16'h0120, 7); exp_wr(16'h0120, wb_word(w2, 1'b0, 8'h33), 5);
        exp_rd(16'h0100, 8);
        @(negedge clk);
        ring_base_i = 16'h0100;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(running_o, "R2 running after start", {31'h0, running_o}, 1);
        chk(mem_req_o && mem_addr_o == 16'h0100, "R2 first read at base", {16'h0, mem_addr_o}, 32'h0100);
        wait_stop("R9 stop after inactive descriptor");
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R9 sequence complete", exp_q.size(), 0);
        chk(mem[8'h44][29] == 1'b1, "R6 abort flag in memory", mem[8'h44], wb_word(w1, 1'b1, 8'h22));

        // Scenario 2: start while running is ignored (R11)
        mem[8'h80] = 32'h8000_0001; mem[8'h84] = 32'h4000_0000; mem[8'hC0] = 32'h8000_0000;
        frm_q.push_back('{ab:1'b0, st:8'h44});
        exp_rd(16'h0200, 2); exp_wr(16'h0200, wb_word(32'h8000_0001, 1'b0, 8'h44), 11);
        exp_rd(16'h0210, 11);
        pulse_start(16'h0200);
        while (!xfer_go_o) @(negedge clk);
        chk(xfer_desc_addr_o == 16'h0200, "R4 descriptor address", {16'h0, xfer_desc_addr_o}, 32'h0200);
        ring_base_i = 16'h0300;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_stop("R11 stop unaffected by extra start");
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R11 sequence complete", exp_q.size(), 0);
        chk(mem[8'hC0] == 32'h8000_0000, "R11 ignored base untouched", mem[8'hC0], 32'h8000_0000);

        // Scenario 3: re-arm and restart, single-entry ring, slow memory (R10 R3 R8)
        lat = 2;
        mem[8'h84] = 32'hC000_0700;
        frm_q.push_back('{ab:1'b0, st:8'h55});
        exp_rd(16'h0210, 10); exp_wr(16'h0210, wb_word(32'hC000_0700, 1'b0, 8'h55), 10);
        exp_rd(16'h0210, 8);
        pulse_start(16'h0210);
        chk(running_o && mem_req_o, "R3 request held while waiting", {30'h0, running_o, mem_req_o}, 32'h3);
        wait_stop("R10 stop after restart");
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R10 sequence complete", exp_q.size(), 0);
        chk(frm_q.size() == 0, "R4 all frames consumed", frm_q.size(), 0);
        chk(mem[8'h84] == 32'h4000_0755, "R5 re-armed write-back", mem[8'h84], 32'h4000_0755);
        finish_run();
    end
endmodule